// File: doc/BRIEF.md
# Multi-Mode Floating-Point Product Rounder

This block is the last, purely combinational stage of a single-precision multiplier datapath. Upstream logic delivers the product sign, a normalized 23-bit fraction, a wide signed biased exponent that may sit below 1 or at or above 255, and the guard, round and sticky bits. It also delivers a flag telling whether both operands were nonzero. The block then produces the packed 32-bit result word: bit 31 is the sign, bits 30:23 are the biased exponent and bits 22:0 are the fraction.

The block supports six rounding directions, chosen by a 3-bit select. It increments the fraction when the selected direction calls for it and folds a fraction carry into the exponent. Results that are too large are clamped to infinity or to the largest finite value. Results that are too small are replaced by a signed zero or by the smallest normal number, depending on the mode and the sign. Subnormal words are never produced.

Top module: `fpr_round_unit`

## Requirements
- R1: Select 000 rounds to nearest with ties to even: the fraction is incremented when guard is set and at least one of round, sticky or fraction bit 0 is set. Selects 110 and 111 act exactly like 000.
- R2: Select 001 rounds toward zero. The fraction is never incremented, for either sign.
- R3: Select 010 rounds toward plus infinity and select 011 toward minus infinity. The fraction is incremented when any of guard, round or sticky is set and the sign is 0 (for 010) or 1 (for 011).
- R4: Select 100 rounds to nearest with ties toward plus infinity. The fraction is incremented when guard is set and either round or sticky is set, or the sign is 0.
- R5: Select 101 rounds away from zero. The fraction is incremented when any of guard, round or sticky is set.
- R6: When the increment carries out of fraction bit 22, the fraction becomes the incremented value shifted right by one and the exponent grows by one. For example, 7FFFFF with an increment becomes 400000.
- R7: When the exponent after rounding is 255 or more, the result is infinity (exponent 255, fraction 0) in modes 000, 100 and 101, and in 010 for sign 0 or 011 for sign 1. In every other case the result is the largest finite magnitude (exponent 254, fraction 7FFFFF) with the result sign.
- R8: When the exponent after rounding is 0 or below and the operands were nonzero, the result is the minimum normal (exponent 1, fraction 0) in mode 101, in 010 for sign 0, and in 011 for sign 1. In every other case the result is a zero with the result sign.
- R9: When the nonzero-operands flag is 0, the result is a zero carrying the result sign, whatever the other inputs are.
- R10: Bit 31 of the result always equals the sign input. An exponent field of all ones always comes with a zero fraction, and an exponent field of zero always comes with a zero fraction.
- R11: With guard, round and sticky all clear, an exponent from 1 to 254 and nonzero operands, the result is the input fields packed unchanged, in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sign_i | input | 1 | Sign of the product |
| frac_i | input | 23 | Normalized fraction before rounding |
| exp_i | input | 10 | Signed biased exponent before rounding |
| grd_i | input | 1 | Guard bit (first bit below the fraction) |
| rnd_i | input | 1 | Round bit (second bit below the fraction) |
| stk_i | input | 1 | Sticky bit (OR of all lower bits) |
| nz_ops_i | input | 1 | High when both operands were nonzero |
| mode_i | input | 3 | Rounding-direction select |
| res_o | output | 32 | Packed result word |

## Verification
The assertions assume that the exponent input holds a value that upstream normalization can produce: a signed number well inside the 10-bit range, so that adding one carry cannot wrap it. They also assume that the guard, round and sticky bits describe the bits below the given fraction. Every stimulus vector uses exponents between -5 and 300 and plain fraction patterns, so it keeps within these limits. The directed vectors cover each mode against ties, inexact values of both signs, fraction carry-out, overflow and tiny results.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

  typedef enum logic [2:0] {
    RM_EVEN   = 3'b000,
    RM_TOZERO = 3'b001,
    RM_UP     = 3'b010,
    RM_DOWN   = 3'b011,
    RM_HALFUP = 3'b100,
    RM_AWAY   = 3'b101
  } rmode_e;

  // Unused select codes fold onto ties-to-even.
  function automatic rmode_e decode_mode(input logic [2:0] sel);
    rmode_e m;
    case (sel)
      3'b001:  m = RM_TOZERO;
      3'b010:  m = RM_UP;
      3'b011:  m = RM_DOWN;
      3'b100:  m = RM_HALFUP;
      3'b101:  m = RM_AWAY;
      default: m = RM_EVEN;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/fpr_incr_decide.sv
module fpr_incr_decide
  import fpr_pkg::*;
(
  input  rmode_e mode,
  input  logic   sign,
  input  logic   lsb,
  input  logic   grd,
  input  logic   rnd,
  input  logic   stk,
  output logic   bump
);

  logic inexact;
  logic above_half;

  always_comb begin
    inexact    = grd | rnd | stk;
    above_half = grd & (rnd | stk);
    case (mode)
      RM_TOZERO: bump = 1'b0;
      RM_UP:     bump = inexact & ~sign;
      RM_DOWN:   bump = inexact & sign;
      RM_HALFUP: bump = above_half | (grd & ~sign);
      RM_AWAY:   bump = inexact;
      default:   bump = above_half | (grd & lsb);
    endcase
  end

endmodule

// File: rtl/fpr_mant_inc.sv
module fpr_mant_inc #(
  parameter int FRAC_W   = 23,
  parameter int EXP_IN_W = 10
) (
  input  logic [FRAC_W-1:0]          frac_in,
  input  logic signed [EXP_IN_W-1:0] exp_in,
  input  logic                       bump,
  output logic [FRAC_W-1:0]          frac_out,
  output logic signed [EXP_IN_W:0]   exp_out
);

  localparam int SUM_W = FRAC_W + 1;

  logic [SUM_W-1:0]        sum;
  logic                    carry;
  logic signed [EXP_IN_W:0] exp_wide;

  always_comb begin
    sum      = {1'b0, frac_in} + {{FRAC_W{1'b0}}, bump};
    carry    = sum[FRAC_W];
    frac_out = carry ? sum[FRAC_W:1] : sum[FRAC_W-1:0];
    exp_wide = {exp_in[EXP_IN_W-1], exp_in};
    exp_out  = exp_wide + $signed({{EXP_IN_W{1'b0}}, carry});
  end

endmodule

// File: rtl/fpr_range_fix.sv
module fpr_range_fix
  import fpr_pkg::*;
#(
  parameter int FRAC_W   = 23,
  parameter int EXP_W    = 8,
  parameter int EXP_IN_W = 10
) (
  input  rmode_e                   mode,
  input  logic                     sign,
  input  logic                     nz_ops,
  input  logic [FRAC_W-1:0]        frac,
  input  logic signed [EXP_IN_W:0] exp_r,
  output logic [EXP_W+FRAC_W:0]    word
);

  localparam int EXP_ALL_INT = (1 << EXP_W) - 1;
  localparam logic signed [EXP_IN_W:0] EXP_TOP  = EXP_IN_W'(EXP_ALL_INT);
  localparam logic signed [EXP_IN_W:0] EXP_NONE = '0;
  localparam logic [EXP_W-1:0]  E_ONES = '1;
  localparam logic [EXP_W-1:0]  E_MAXF = E_ONES - 1'b1;
  localparam logic [EXP_W-1:0]  E_MIN  = EXP_W'(1);
  localparam logic [FRAC_W-1:0] F_ZERO = '0;
  localparam logic [FRAC_W-1:0] F_ONES = '1;

  logic toward_sign;
  logic to_inf;
  logic force_min;
  logic ovf;
  logic tiny;

  always_comb begin
    toward_sign = ((mode == RM_UP) & ~sign) | ((mode == RM_DOWN) & sign);
    to_inf      = (mode == RM_EVEN) | (mode == RM_HALFUP) |
                  (mode == RM_AWAY) | toward_sign;
    force_min   = (mode == RM_AWAY) | toward_sign;
    ovf         = exp_r >= EXP_TOP;
    tiny        = exp_r <= EXP_NONE;

    if (!nz_ops) begin
      word = {sign, {EXP_W{1'b0}}, F_ZERO};
    end else if (ovf) begin
      word = to_inf ? {sign, E_ONES, F_ZERO} : {sign, E_MAXF, F_ONES};
    end else if (tiny) begin
      word = force_min ? {sign, E_MIN, F_ZERO} : {sign, {EXP_W{1'b0}}, F_ZERO};
    end else begin
      word = {sign, exp_r[EXP_W-1:0], frac};
    end
  end

endmodule

// File: rtl/fpr_round_unit.sv
module fpr_round_unit
  import fpr_pkg::*;
#(
  parameter int FRAC_W   = 23,
  parameter int EXP_W    = 8,
  parameter int EXP_IN_W = 10
) (
  input  logic                       sign_i,
  input  logic [FRAC_W-1:0]          frac_i,
  input  logic signed [EXP_IN_W-1:0] exp_i,
  input  logic                       grd_i,
  input  logic                       rnd_i,
  input  logic                       stk_i,
  input  logic                       nz_ops_i,
  input  logic [2:0]                 mode_i,
  output logic [EXP_W+FRAC_W:0]      res_o
);

  rmode_e                   mode_n;
  logic                     bump;
  logic [FRAC_W-1:0]        frac_r;
  logic signed [EXP_IN_W:0] exp_r;

  assign mode_n = decode_mode(mode_i);

  fpr_incr_decide u_decide (
    .mode (mode_n),
    .sign (sign_i),
    .lsb  (frac_i[0]),
    .grd  (grd_i),
    .rnd  (rnd_i),
    .stk  (stk_i),
    .bump (bump)
  );

  fpr_mant_inc #(
    .FRAC_W   (FRAC_W),
    .EXP_IN_W (EXP_IN_W)
  ) u_inc (
    .frac_in  (frac_i),
    .exp_in   (exp_i),
    .bump     (bump),
    .frac_out (frac_r),
    .exp_out  (exp_r)
  );

  fpr_range_fix #(
    .FRAC_W   (FRAC_W),
    .EXP_W    (EXP_W),
    .EXP_IN_W (EXP_IN_W)
  ) u_fix (
    .mode   (mode_n),
    .sign   (sign_i),
    .nz_ops (nz_ops_i),
    .frac   (frac_r),
    .exp_r  (exp_r),
    .word   (res_o)
  );

endmodule

// File: rtl/fpr_round_unit_chk.sv
module fpr_round_unit_chk #(
  parameter int FRAC_W   = 23,
  parameter int EXP_W    = 8,
  parameter int EXP_IN_W = 10
) (
  input logic                       sign_i,
  input logic [FRAC_W-1:0]          frac_i,
  input logic signed [EXP_IN_W-1:0] exp_i,
  input logic                       grd_i,
  input logic                       rnd_i,
  input logic                       stk_i,
  input logic                       nz_ops_i,
  input logic [2:0]                 mode_i,
  input logic [EXP_W+FRAC_W:0]      res_o
);

  localparam int TOP = EXP_W + FRAC_W;
  localparam logic signed [EXP_IN_W-1:0] E_LO = EXP_IN_W'(1);
  localparam logic signed [EXP_IN_W-1:0] E_HI = EXP_IN_W'((1 << EXP_W) - 2);

  logic [EXP_W-1:0]  r_exp;
  logic [FRAC_W-1:0] r_frac;
  logic              in_range;

  always_comb begin
    r_exp    = res_o[TOP-1:FRAC_W];
    r_frac   = res_o[FRAC_W-1:0];
    in_range = (exp_i >= E_LO) && (exp_i <= E_HI);

    p_sign_kept_r10: assert (res_o[TOP] == sign_i)
      else $error("result sign differs from sign input");
    p_inf_clean_r10: assert (!(&r_exp) || (r_frac == '0))
      else $error("all-ones exponent with nonzero fraction");
    p_no_subnormal_r8: assert ((r_exp != '0) || (r_frac == '0))
      else $error("subnormal word produced");
    p_zero_operand_r9: assert (nz_ops_i || (res_o[TOP-1:0] == '0))
      else $error("zero operand gave nonzero magnitude");
    p_truncate_r2: assert (!(mode_i == 3'b001 && nz_ops_i && in_range) ||
                           (r_frac == frac_i))
      else $error("toward-zero mode changed the fraction");
    p_exact_r11: assert (!(nz_ops_i && in_range && !grd_i && !rnd_i && !stk_i) ||
                         (res_o == {sign_i, exp_i[EXP_W-1:0], frac_i}))
      else $error("exact value altered");
  end

endmodule

bind fpr_round_unit fpr_round_unit_chk #(
  .FRAC_W   (FRAC_W),
  .EXP_W    (EXP_W),
  .EXP_IN_W (EXP_IN_W)
) u_chk (
  .sign_i   (sign_i),
  .frac_i   (frac_i),
  .exp_i    (exp_i),
  .grd_i    (grd_i),
  .rnd_i    (rnd_i),
  .stk_i    (stk_i),
  .nz_ops_i (nz_ops_i),
  .mode_i   (mode_i),
  .res_o    (res_o)
);

// File: tb/fpr_round_unit_test.sv
`timescale 1ns/1ps
module fpr_round_unit_test;

  logic              clk;
  logic              sign_i;
  logic [22:0]       frac_i;
  logic signed [9:0] exp_i;
  logic              grd_i, rnd_i, stk_i, nz_ops_i;
  logic [2:0]        mode_i;
  logic [31:0]       res_o;

  int n_vec;
  int n_bad;
  bit done;

  fpr_round_unit uut (
    .sign_i   (sign_i),
    .frac_i   (frac_i),
    .exp_i    (exp_i),
    .grd_i    (grd_i),
    .rnd_i    (rnd_i),
    .stk_i    (stk_i),
    .nz_ops_i (nz_ops_i),
    .mode_i   (mode_i),
    .res_o    (res_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic vec(input string tag, input bit s, input logic [22:0] f,
                     input int e, input bit g, input bit r, input bit st,
                     input bit nz, input logic [2:0] m, input logic [31:0] want);
    @(negedge clk);
    sign_i = s; frac_i = f; exp_i = e[9:0];
    grd_i = g; rnd_i = r; stk_i = st; nz_ops_i = nz; mode_i = m;
    @(posedge clk);
    #1;
    n_vec++;
    if (res_o !== want) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, res_o, want);
    end
  endtask

  task automatic t_initial;
    #1;
    n_vec++;
    if (res_o !== 32'h0) begin
      n_bad++;
      $display("FAIL R9 initial: got %h expected %h", res_o, 32'h0);
    end
  endtask

  task automatic t_even;
    vec("R1 tie even lsb",   0, 23'h400000, 100, 1,0,0, 1, 3'b000, 32'h32400000);
    vec("R1 tie odd lsb",    0, 23'h400001, 100, 1,0,0, 1, 3'b000, 32'h32400002);
    vec("R1 above half",     0, 23'h123456, 100, 1,0,1, 1, 3'b000, 32'h32123457);
    vec("R1 below half",     0, 23'h123456, 100, 0,1,1, 1, 3'b000, 32'h32123456);
    vec("R1 code 110",       0, 23'h400001, 100, 1,0,0, 1, 3'b110, 32'h32400002);
    vec("R1 code 111",       1, 23'h400001, 100, 1,0,0, 1, 3'b111, 32'hB2400002);
  endtask

  task automatic t_tozero;
    vec("R2 pos grs",        0, 23'h123456, 100, 1,1,1, 1, 3'b001, 32'h32123456);
    vec("R2 neg grs",        1, 23'h123456, 100, 1,1,1, 1, 3'b001, 32'hB2123456);
  endtask

  task automatic t_directed;
    vec("R3 up pos",         0, 23'h123456, 100, 0,0,1, 1, 3'b010, 32'h32123457);
    vec("R3 up neg",         1, 23'h123456, 100, 0,0,1, 1, 3'b010, 32'hB2123456);
    vec("R3 down neg",       1, 23'h123456, 100, 0,0,1, 1, 3'b011, 32'hB2123457);
    vec("R3 down pos",       0, 23'h123456, 100, 0,0,1, 1, 3'b011, 32'h32123456);
  endtask

  task automatic t_halfup;
    vec("R4 tie pos",        0, 23'h400000, 100, 1,0,0, 1, 3'b100, 32'h32400001);
    vec("R4 tie neg",        1, 23'h400000, 100, 1,0,0, 1, 3'b100, 32'hB2400000);
    vec("R4 above neg",      1, 23'h400000, 100, 1,0,1, 1, 3'b100, 32'hB2400001);
    vec("R4 below pos",      0, 23'h400000, 100, 0,1,0, 1, 3'b100, 32'h32400000);
  endtask

  task automatic t_away;
    vec("R5 pos round bit",  0, 23'h123456, 100, 0,1,0, 1, 3'b101, 32'h32123457);
    vec("R5 neg sticky",     1, 23'h123456, 100, 0,0,1, 1, 3'b101, 32'hB2123457);
  endtask

  task automatic t_carry;
    vec("R6 carry even",     0, 23'h7FFFFF, 100, 1,1,1, 1, 3'b000, 32'h32C00000);
    vec("R6 carry from tiny",0, 23'h7FFFFF,   0, 1,0,1, 1, 3'b000, 32'h00C00000);
    vec("R6 carry to inf",   0, 23'h7FFFFF, 254, 1,1,1, 1, 3'b000, 32'h7F800000);
  endtask

  task automatic t_overflow;
    vec("R7 even inf",       0, 23'h000000, 255, 0,0,0, 1, 3'b000, 32'h7F800000);
    vec("R7 tozero max",     0, 23'h000000, 300, 0,0,0, 1, 3'b001, 32'h7F7FFFFF);
    vec("R7 up neg max",     1, 23'h000000, 260, 0,0,0, 1, 3'b010, 32'hFF7FFFFF);
    vec("R7 up pos inf",     0, 23'h000000, 260, 0,0,0, 1, 3'b010, 32'h7F800000);
    vec("R7 down neg inf",   1, 23'h000000, 260, 0,0,0, 1, 3'b011, 32'hFF800000);
    vec("R7 down pos max",   0, 23'h000000, 260, 0,0,0, 1, 3'b011, 32'h7F7FFFFF);
    vec("R7 halfup neg inf", 1, 23'h000000, 260, 0,0,0, 1, 3'b100, 32'hFF800000);
    vec("R7 away pos inf",   0, 23'h000000, 260, 0,0,0, 1, 3'b101, 32'h7F800000);
  endtask

  task automatic t_tiny;
    vec("R8 even pos",       0, 23'h123456,  0, 0,0,0, 1, 3'b000, 32'h00000000);
    vec("R8 even neg",       1, 23'h123456,  0, 0,0,0, 1, 3'b000, 32'h80000000);
    vec("R8 tozero neg",     1, 23'h123456, -5, 1,1,1, 1, 3'b001, 32'h80000000);
    vec("R8 away pos",       0, 23'h123456,  0, 0,0,0, 1, 3'b101, 32'h00800000);
    vec("R8 away neg",       1, 23'h000000, -3, 0,0,1, 1, 3'b101, 32'h80800000);
    vec("R8 up pos",         0, 23'h123456,  0, 0,0,0, 1, 3'b010, 32'h00800000);
    vec("R8 up neg",         1, 23'h123456,  0, 0,0,0, 1, 3'b010, 32'h80000000);
    vec("R8 down neg",       1, 23'h123456,  0, 0,0,0, 1, 3'b011, 32'h80800000);
    vec("R8 down pos",       0, 23'h123456,  0, 0,0,0, 1, 3'b011, 32'h00000000);
    vec("R8 halfup pos",     0, 23'h123456,  0, 1,0,0, 1, 3'b100, 32'h00000000);
  endtask

  task automatic t_zero_ops;
    vec("R9 away neg",       1, 23'h123456, 100, 1,0,0, 0, 3'b101, 32'h80000000);
    vec("R9 up pos tiny",    0, 23'h123456,   0, 0,0,1, 0, 3'b010, 32'h00000000);
  endtask

  task automatic t_fields;
    vec("R10 inf clean",     0, 23'h123456, 255, 0,0,0, 1, 3'b000, 32'h7F800000);
    vec("R10 neg sign",      1, 23'h000001, 127, 0,0,0, 1, 3'b001, 32'hBF800001);
  endtask

  task automatic t_exact;
    for (int m = 0; m < 8; m++) begin
      vec("R11 exact pos", 0, 23'h123456, 100, 0,0,0, 1, m[2:0], 32'h32123456);
      vec("R11 exact neg", 1, 23'h2AAAAA,   1, 0,0,0, 1, m[2:0], 32'h80AAAAAA);
    end
  endtask

  initial begin
    n_vec = 0; n_bad = 0; done = 1'b0;
    sign_i = 1'b0; frac_i = '0; exp_i = '0;
    grd_i = 1'b0; rnd_i = 1'b0; stk_i = 1'b0; nz_ops_i = 1'b0; mode_i = 3'b000;
    t_initial();
    t_even();
    t_tozero();
    t_directed();
    t_halfup();
    t_away();
    t_carry();
    t_overflow();
    t_tiny();
    t_zero_ops();
    t_fields();
    t_exact();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule